// File: doc/BRIEF.md
# Floating-Point Operand Unpack Classifier

This unit takes one operand held in a group of four 32-bit words and turns it into a wide internal form that later arithmetic can work on directly. The internal form has a sign, a signed unbiased exponent, a 113-bit mantissa that carries its leading one explicitly, and a class code. A two-bit type selector chooses how the words are read: as a 32-bit two's-complement integer, or as an IEEE binary32, binary64 or binary128 value. Any subnormal input, and any non-zero integer, is brought to normalized form by a leading-zero counter and a left shift. A NaN always leaves the unit quiet. A NaN that arrived as signalling is marked by its class code and by an invalid-operation flag.

Operands enter and leave on valid/ready streams with one output register between them. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high, and its result appears on the outputs in the next cycle. The output stage can refill in the same cycle that it drains. Back-pressure is the only flow control: when `out_ready` is low and a result is waiting, the unit stops taking input and keeps every output steady.

Word k of the operand is `in_words[32k+31:32k]`. Word 0 carries the sign, the exponent and the top of the fraction. The lower fraction bits continue through word 1, then word 2, then word 3.

Top module: `fp_unpack`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An operand accepted on a clock edge appears on the outputs, with `out_valid` high, after that same edge. While `out_valid` is high and `out_ready` is low, every output keeps its value. After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `out_sign` is bit 31 of word 0 for every type, including integers.
- R3: A float input with biased exponent 0 and all fraction bits 0 gives class 0 (zero), with `out_exp` 0 and `out_mant` 0. Negative zero keeps sign 1.
- R4: A float input with biased exponent 0 and a non-zero fraction gives class 1 (number). The fraction is left-aligned at mantissa bit 111 with no implicit one. It is then shifted left until bit 112 is set, and `out_exp` is 1 − bias − shift.
- R5: A float input whose biased exponent is neither 0 nor the maximum gives class 1. `out_exp` is the biased exponent minus the bias, and `out_mant` is a one at bit 112 with the fraction left-aligned beneath it, starting at bit 111.
- R6: A float input with the maximum biased exponent and a zero fraction gives class 2 (infinity), with `out_exp` 0 and `out_mant` 0.
- R7: A float input with the maximum biased exponent, a non-zero fraction and its top fraction bit set gives class 3 (quiet NaN). `out_mant` holds the fraction left-aligned at bit 111 and nothing else, `out_exp` is 0, and `out_invalid` is 0.
- R8: A float input with the maximum biased exponent, a non-zero fraction and its top fraction bit clear gives class 4 (signalling NaN) and `out_invalid` 1. `out_mant` is the aligned fraction with bit 111 forced to 1, and `out_exp` is 0. `out_invalid` is 0 for every other class.
- R9: Integer type: word 0 equal to 0 gives class 0. Any other value gives class 1. Its magnitude is the absolute value (0x80000000 has magnitude 2^31), and it is placed at mantissa bit 0 with exponent 112. It is then normalized as in R4, so `out_exp` is the index of the magnitude's top set bit.
- R10: Fraction and exponent fields are as follows. binary32 uses exponent word0[30:23], bias 127, and fraction word0[22:0]. binary64 uses exponent word0[30:20], bias 1023, and fraction {word0[19:0], word1}. binary128 uses exponent word0[30:16], bias 16383, and fraction {word0[15:0], word1, word2, word3}. Words not listed for a type have no effect on any output.
- R11: `in_fmt` encodes 0 = integer, 1 = binary32, 2 = binary64, 3 = binary128. `out_class` is always one of the codes 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_fmt | input | 2 | Type selector |
| in_words | input | 128 | Four operand words; word k at bits 32k+31:32k |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sign | output | 1 | Sign |
| out_exp | output | 18 | Signed unbiased exponent |
| out_mant | output | 113 | Mantissa, leading one at bit 112 for numbers |
| out_class | output | 3 | Class code |
| out_invalid | output | 1 | Signalling NaN seen |

## Verification
The unit holds no state other than its output register, so any fault shows up on the result of the operand it affects, one cycle after that operand is accepted. A wrong leading-zero count appears as a mantissa whose bit 112 is clear, or as an exponent off by the miscount. A slip in word ordering or field position shows up only for the wider types and for subnormals whose set bits fall in the lower words. A flow-control fault shows up as a result that changes or vanishes while back-pressure is applied.

// File: rtl/fp_unpack_pkg.sv
package fp_unpack_pkg;
  localparam int UNP_MANT_W = 113;
  localparam int UNP_EXP_W  = 18;
  localparam int UNP_WORD_W = 32;
  localparam int UNP_NWORDS = 4;

  typedef enum logic [1:0] {
    FMT_INT = 2'd0,
    FMT_B32 = 2'd1,
    FMT_B64 = 2'd2,
    FMT_B128 = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } cls_e;
endpackage

// File: rtl/unp_float_fields.sv
module unp_float_fields
  import fp_unpack_pkg::*;
#(
  parameter int EXP_BITS  = 8,
  parameter int FRAC_BITS = 23,
  parameter int MANT_W    = UNP_MANT_W,
  parameter int EXP_W     = UNP_EXP_W
) (
  input  logic [EXP_BITS+FRAC_BITS-1:0] body,
  output logic signed [EXP_W-1:0]       exp_o,
  output logic [MANT_W-1:0]             mant_o,
  output cls_e                          cls_o
);
  localparam int BIAS = (1 << (EXP_BITS - 1)) - 1;
  localparam int FA_W = MANT_W - 1;

  logic [EXP_BITS-1:0]  biased;
  logic [FRAC_BITS-1:0] frac;
  logic [FA_W-1:0]      aligned;

  assign biased  = body[EXP_BITS+FRAC_BITS-1 -: EXP_BITS];
  assign frac    = body[FRAC_BITS-1:0];
  assign aligned = FA_W'(frac) << (FA_W - FRAC_BITS);

  always_comb begin
    exp_o  = '0;
    mant_o = '0;
    cls_o  = CLS_ZERO;
    if (biased == '0) begin
      if (frac != '0) begin
        cls_o  = CLS_NUM;
        exp_o  = EXP_W'(1) - EXP_W'(BIAS);
        mant_o = {1'b0, aligned};
      end
    end else if (&biased) begin
      if (frac == '0) begin
        cls_o = CLS_INF;
      end else begin
        cls_o  = CLS_QNAN;
        mant_o = {1'b0, aligned};
      end
    end else begin
      cls_o  = CLS_NUM;
      exp_o  = EXP_W'(biased) - EXP_W'(BIAS);
      mant_o = {1'b1, aligned};
    end
  end
endmodule

// File: rtl/unp_int_fields.sv
module unp_int_fields
  import fp_unpack_pkg::*;
#(
  parameter int WORD_W = UNP_WORD_W,
  parameter int MANT_W = UNP_MANT_W,
  parameter int EXP_W  = UNP_EXP_W
) (
  input  logic [WORD_W-1:0]       word,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [MANT_W-1:0]       mant_o,
  output cls_e                    cls_o
);
  logic [WORD_W-1:0] mag;

  assign mag = word[WORD_W-1] ? (~word + 1'b1) : word;

  always_comb begin
    if (word == '0) begin
      cls_o  = CLS_ZERO;
      exp_o  = '0;
      mant_o = '0;
    end else begin
      cls_o  = CLS_NUM;
      exp_o  = EXP_W'(MANT_W - 1);
      mant_o = MANT_W'(mag);
    end
  end
endmodule

// File: rtl/unp_normalize.sv
module unp_normalize #(
  parameter int MANT_W = 113,
  parameter int EXP_W  = 18
) (
  input  logic                    en,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic signed [EXP_W-1:0] exp_i,
  output logic [MANT_W-1:0]       mant_o,
  output logic signed [EXP_W-1:0] exp_o
);
  localparam int CNT_W = $clog2(MANT_W);

  logic [CNT_W-1:0] lead_zeros;

  always_comb begin
    lead_zeros = '0;
    for (int i = 0; i < MANT_W; i++) begin
      if (mant_i[i]) lead_zeros = CNT_W'(MANT_W - 1 - i);
    end
  end

  assign mant_o = en ? (mant_i << lead_zeros) : mant_i;
  assign exp_o  = en ? (exp_i - EXP_W'(lead_zeros)) : exp_i;

  always_comb begin
    if (en && (mant_i != '0)) begin
      assert_norm_msb_R4: assert (mant_o[MANT_W-1])
        else $error("normalized mantissa lacks leading one");
    end
  end
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
  import fp_unpack_pkg::*;
#(
  parameter int WORD_W   = UNP_WORD_W,
  parameter int NWORDS   = UNP_NWORDS,
  parameter int MANT_W   = UNP_MANT_W,
  parameter int EXP_W    = UNP_EXP_W,
  parameter int B32_EXP  = 8,
  parameter int B32_FRAC = 23,
  parameter int B64_EXP  = 11,
  parameter int B64_FRAC = 52,
  parameter int B128_EXP = 15,
  parameter int B128_FRAC = 112
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_fmt,
  input  logic [WORD_W*NWORDS-1:0] in_words,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_sign,
  output logic signed [EXP_W-1:0] out_exp,
  output logic [MANT_W-1:0]       out_mant,
  output logic [2:0]              out_class,
  output logic                    out_invalid
);
  localparam int IN_W  = WORD_W * NWORDS;
  localparam int QUIET = MANT_W - 2;

  // word 0 first, so fields read most-significant first
  logic [IN_W-1:0] stream;
  for (genvar k = 0; k < NWORDS; k++) begin : g_order
    assign stream[IN_W-1-k*WORD_W -: WORD_W] = in_words[k*WORD_W +: WORD_W];
  end

  logic signed [EXP_W-1:0] cand_exp  [0:3];
  logic [MANT_W-1:0]       cand_mant [0:3];
  cls_e                    cand_cls  [0:3];

  unp_int_fields #(.WORD_W(WORD_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_int (
    .word  (in_words[WORD_W-1:0]),
    .exp_o (cand_exp[0]),
    .mant_o(cand_mant[0]),
    .cls_o (cand_cls[0])
  );

  for (genvar g = 1; g < 4; g++) begin : g_float
    localparam int EB = (g == 1) ? B32_EXP  : (g == 2) ? B64_EXP  : B128_EXP;
    localparam int FB = (g == 1) ? B32_FRAC : (g == 2) ? B64_FRAC : B128_FRAC;
    unp_float_fields #(.EXP_BITS(EB), .FRAC_BITS(FB), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_fields (
      .body  (stream[IN_W-2 -: EB+FB]),
      .exp_o (cand_exp[g]),
      .mant_o(cand_mant[g]),
      .cls_o (cand_cls[g])
    );
  end

  cls_e                    sel_cls;
  logic signed [EXP_W-1:0] sel_exp;
  logic [MANT_W-1:0]       sel_mant;

  assign sel_cls  = cand_cls[in_fmt];
  assign sel_exp  = cand_exp[in_fmt];
  assign sel_mant = cand_mant[in_fmt];

  logic [MANT_W-1:0]       norm_mant;
  logic signed [EXP_W-1:0] norm_exp;

  unp_normalize #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_norm (
    .en    (sel_cls == CLS_NUM),
    .mant_i(sel_mant),
    .exp_i (sel_exp),
    .mant_o(norm_mant),
    .exp_o (norm_exp)
  );

  cls_e              fin_cls;
  logic [MANT_W-1:0] fin_mant;
  logic              fin_inv;

  always_comb begin
    fin_cls  = sel_cls;
    fin_mant = norm_mant;
    fin_inv  = 1'b0;
    if (sel_cls == CLS_QNAN && !norm_mant[QUIET]) begin
      fin_cls         = CLS_SNAN;
      fin_mant[QUIET] = 1'b1;
      fin_inv         = 1'b1;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_mant    <= '0;
      out_class   <= CLS_ZERO;
      out_invalid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign    <= in_words[WORD_W-1];
        out_exp     <= norm_exp;
        out_mant    <= fin_mant;
        out_class   <= fin_cls;
        out_invalid <= fin_inv;
      end
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_exp)
      && $stable(out_class) && $stable(out_sign) && $stable(out_invalid));

  assert_num_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == CLS_NUM |-> out_mant[MANT_W-1]);

  assert_nan_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == CLS_QNAN || out_class == CLS_SNAN) |-> out_mant[QUIET]);

  assert_empty_mant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == CLS_ZERO || out_class == CLS_INF) |-> out_mant == '0);

  assert_class_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_class <= 3'd4);

  assert_inv_only_snan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class != CLS_SNAN |-> !out_invalid);
endmodule

// File: tb/fp_unpack_bench.sv
`timescale 1ns/1ps
module fp_unpack_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_fmt = 2'd0;
  logic [127:0] in_words = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_sign;
  logic [17:0]  out_exp;
  logic [112:0] out_mant;
  logic [2:0]   out_class;
  logic         out_invalid;

  int tests_run = 0;
  int tests_failed = 0;

  always #4 clk = ~clk;

  fp_unpack u_fp_unpack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_words(in_words), .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant),
    .out_class(out_class), .out_invalid(out_invalid)
  );

  typedef struct packed {
    logic         sign;
    logic [17:0]  exp;
    logic [112:0] mant;
    logic [2:0]   cls;
    logic         inv;
  } res_t;

  function automatic res_t model(input logic [1:0] f, input logic [127:0] w);
    res_t r;
    int e, eb, fb, bias, be;
    logic [111:0] fa;
    logic [127:0] st;
    logic [31:0] mag;
    r = '0;
    r.sign = w[31];
    st = {w[31:0], w[63:32], w[95:64], w[127:96]};
    if (f == 2'd0) begin
      if (w[31:0] != 0) begin
        mag = w[31] ? (~w[31:0] + 32'd1) : w[31:0];
        r.mant = {81'd0, mag};
        e = 112;
        for (int i = 0; i < 113; i++) if (!r.mant[112]) begin r.mant = r.mant << 1; e--; end
        r.exp = e[17:0];
        r.cls = 3'd1;
      end
      return r;
    end
    eb = (f == 2'd1) ? 8 : (f == 2'd2) ? 11 : 15;
    fb = (f == 2'd1) ? 23 : (f == 2'd2) ? 52 : 112;
    bias = (1 << (eb - 1)) - 1;
    be = 0;
    for (int i = 0; i < eb; i++) be = be | (int'(st[126 - i]) << (eb - 1 - i));
    fa = '0;
    for (int i = 0; i < fb; i++) fa[111 - i] = st[126 - eb - i];
    if (be == 0) begin
      if (fa != 0) begin
        r.mant = {1'b0, fa};
        e = 1 - bias;
        for (int i = 0; i < 113; i++) if (!r.mant[112]) begin r.mant = r.mant << 1; e--; end
        r.exp = e[17:0];
        r.cls = 3'd1;
      end
    end else if (be == (1 << eb) - 1) begin
      if (fa == 0) r.cls = 3'd2;
      else begin
        r.mant = {1'b0, fa};
        if (fa[111]) r.cls = 3'd3;
        else begin r.cls = 3'd4; r.inv = 1'b1; r.mant[111] = 1'b1; end
      end
    end else begin
      e = be - bias;
      r.exp = e[17:0];
      r.mant = {1'b1, fa};
      r.cls = 3'd1;
    end
    return r;
  endfunction

  task automatic compare(input res_t exp_r, input string tag);
    res_t act;
    act = {out_sign, out_exp, out_mant, out_class, out_invalid};
    tests_run++;
    if (!out_valid || act !== exp_r) begin
      tests_failed++;
      $display("FAIL %s: valid=%0b sign=%0b exp=%0d mant=%h cls=%0d inv=%0b | expected sign=%0b exp=%0d mant=%h cls=%0d inv=%0b",
               tag, out_valid, act.sign, $signed(act.exp), act.mant, act.cls, act.inv,
               exp_r.sign, $signed(exp_r.exp), exp_r.mant, exp_r.cls, exp_r.inv);
    end
  endtask

  // drive at negedge, accepted at next posedge, checked at the negedge after
  task automatic run_one(input logic [1:0] f, input logic [127:0] w, input string tag);
    @(negedge clk);
    in_fmt = f; in_words = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare(model(f, w), tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    tests_run++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      tests_failed++;
      $display("FAIL R1: reset valid=%0b ready=%0b expected valid=0 ready=1", out_valid, in_ready);
    end
  endtask

  task automatic t_integers;
    run_one(2'd0, 128'd0, "R9 int zero");
    run_one(2'd0, 128'd1, "R9 int one");
    run_one(2'd0, {96'd0, 32'hFFFF_FFFF}, "R9 R2 int minus one");
    run_one(2'd0, {96'd0, 32'h8000_0000}, "R9 R2 int most negative");
    run_one(2'd0, {96'd0, 32'h7FFF_FFFF}, "R9 int max positive");
    run_one(2'd0, {32'hDEAD_BEEF, 64'd0, 32'h0000_0300}, "R10 R9 int upper words ignored");
  endtask

  task automatic t_b32;
    run_one(2'd1, {96'd0, 32'h3F80_0000}, "R5 b32 one");
    run_one(2'd1, {96'd0, 32'hC120_0000}, "R5 R2 b32 minus ten");
    run_one(2'd1, {96'd0, 32'h0000_0001}, "R4 b32 smallest subnormal");
    run_one(2'd1, {96'd0, 32'h8000_0000}, "R3 R2 b32 negative zero");
    run_one(2'd1, {96'd0, 32'h7F80_0000}, "R6 b32 inf");
    run_one(2'd1, {96'd0, 32'h7FC0_0001}, "R7 b32 qnan");
    run_one(2'd1, {96'd0, 32'h7F80_0001}, "R8 b32 snan");
    run_one(2'd1, {32'hFFFF_FFFF, 32'h1234_5678, 32'h0F0F_0F0F, 32'h3F80_0000}, "R10 b32 upper words ignored");
  endtask

  task automatic t_b64;
    run_one(2'd2, {64'd0, 32'd0, 32'h3FF0_0000}, "R5 b64 one");
    run_one(2'd2, {64'd0, 32'd1, 32'h0000_0000}, "R4 R10 b64 smallest subnormal");
    run_one(2'd2, {64'd0, 32'd1, 32'h7FF0_0000}, "R8 R10 b64 snan low word");
    run_one(2'd2, {64'd0, 32'd0, 32'hFFF0_0000}, "R6 b64 neg inf");
    run_one(2'd2, {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'h0000_0000}, "R10 R3 b64 upper words ignored");
  endtask

  task automatic t_b128;
    run_one(2'd3, {96'd0, 32'h3FFF_0000}, "R5 b128 one");
    run_one(2'd3, {32'd1, 64'd0, 32'h0000_0000}, "R4 R10 b128 smallest subnormal");
    run_one(2'd3, {96'd0, 32'h7FFF_0000}, "R6 b128 inf");
    run_one(2'd3, {32'd1, 64'd0, 32'h7FFF_0000}, "R8 b128 snan last word");
    run_one(2'd3, {96'd0, 32'h7FFF_8000}, "R7 b128 qnan");
  endtask

  task automatic t_random;
    for (int n = 0; n < 200; n++) begin
      logic [127:0] w;
      w = {$urandom, $urandom, $urandom, $urandom};
      if (n % 5 == 0) w[30:16] = '0;
      if (n % 7 == 0) w[30:16] = 15'h7FFF;
      run_one(2'(n % 4), w, "R11 random");
    end
  endtask

  task automatic t_backpressure;
    logic [127:0] wa, wb;
    wa = {96'd0, 32'h4000_0000};
    wb = {96'd0, 32'hBF80_0000};
    @(negedge clk);
    out_ready = 1'b0;
    in_fmt = 2'd1; in_words = wa; in_valid = 1'b1;
    @(negedge clk);
    in_words = wb;
    tests_run++;
    if (in_ready !== 1'b0) begin
      tests_failed++;
      $display("FAIL R1: in_ready=%0b expected 0 while stalled", in_ready);
    end
    repeat (2) @(negedge clk);
    compare(model(2'd1, wa), "R1 held under back-pressure");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare(model(2'd1, wb), "R1 next after release");
  endtask

  initial begin : watchdog
    #(8 * 150000);
    tests_failed++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_integers();
    t_b32();
    t_b64();
    t_b128();
    t_backpressure();
    t_random();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule